// File: doc/BRIEF.md
# Floating Word to Integer Converter

This block turns a 36-bit floating word into a 36-bit two's-complement integer. The word holds a sign bit, an 8-bit exponent stored with a bias of 128, and a 27-bit fraction. A negative value is the two's complement of the whole positive word. Each conversion is requested by a one-cycle strobe with the word and a rounding-mode bit. One clock later the registered integer appears with a matching strobe. An overflow flag is raised when the magnitude cannot be represented.

The exponent fixes where the binary point falls within the signed fraction. A barrel shifter moves the fraction so that the integer bits and the bits below the point sit in fixed fields. Both rounding modes work the same way: one constant, chosen by mode and sign, is added to the part below the point. A carry out of that addition increments the integer. There is no per-mode compare logic.

Top module: `fx_float_to_int`

## Requirements
- R1: The sign is bit 35. The exponent e is bits 34:27 for a positive word and the bitwise complement of bits 34:27 for a negative word. The signed fraction M is the 28-bit value {bit 35, bits 26:0}. The value converted is M·2^(e−155).
- R2: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low in every other cycle.
- R3: When e ≥ 164, the cycle with `out_valid` also has `out_ovf` high, and `out_int` keeps the value it held before.
- R4: `out_ovf` is never high without `out_valid`, and a conversion with e < 164 returns with `out_ovf` low.
- R5: When e < 128, the result is 0 in both modes and for both signs.
- R6: With `in_round` = 0 and a positive word, the bits below the binary point are dropped.
- R7: With `in_round` = 0 and a negative word, a nonzero part below the point adds one to the integer, so the result moves toward zero. A negative value with no bits below the point is returned exactly.
- R8: With `in_round` = 1, one-half is added before the bits below the point are dropped. A remainder of one-half or more rounds up (−2.5 gives −2, 2.5 gives 3, −2.75 gives −3).
- R9: For 155 ≤ e ≤ 163, the result is M shifted left by e−155, with no rounding effect.
- R10: While `rst_n` is low at a clock edge, `out_valid`, `out_ovf` and `out_int` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Convert the word on `in_word` this cycle |
| in_word | input | 36 | Floating word to convert |
| in_round | input | 1 | 1 = round half up, 0 = drop fraction toward zero |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_int | output | 36 | Registered two's-complement integer |
| out_ovf | output | 1 | Value out of range; `out_int` kept unchanged |

## Verification
Two things happen in the same result cycle and must be judged together: the overflow flag rises with the valid strobe, and the integer register holds its previous contents. The bench provokes this by placing an out-of-range word directly after an ordinary conversion. It then places two out-of-range words back to back. The scoreboard expects the flag together with the integer from the last in-range conversion, so a design that loads a partial value, or that raises the flag a cycle late, is caught.

// File: rtl/fx_pkg.sv
// Package: shared types for the float-to-integer converter.
// Assumes: nothing beyond IEEE 1800-2017.
package fx_pkg;

    // Range class of an incoming word, decided from its exponent alone
    typedef enum logic [1:0] {
        CLS_NORMAL = 2'd0,
        CLS_ZERO   = 2'd1,
        CLS_OVF    = 2'd2
    } fx_cls_e;

    // Rounding mode as driven on the mode input
    typedef enum logic {
        RND_TOWARD_ZERO = 1'b0,
        RND_HALF_UP     = 1'b1
    } fx_rnd_e;

endpackage

// File: rtl/fx_unpack.sv
// Module: fx_unpack
// Splits a floating word into its true exponent and signed fraction,
// and classifies the word as in range, too small, or too large.
// Assumes: negative words are the two's complement of the whole word,
// so the exponent field of a negative word is stored complemented.
module fx_unpack
    import fx_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int EXP_W  = 8
) (
    input  logic [WORD_W-1:0]   word,
    output logic [EXP_W-1:0]    exp_u,
    output logic [WORD_W-EXP_W-1:0] mant,
    output fx_cls_e             cls
);
    localparam int FRAC_W = WORD_W - 1 - EXP_W;
    localparam int BIAS   = 1 << (EXP_W - 1);
    localparam logic [EXP_W:0] ZERO_LIM = (EXP_W+1)'(BIAS);
    localparam logic [EXP_W:0] OVF_LIM  = (EXP_W+1)'(BIAS + WORD_W);

    logic sgn;

    // Recover the exponent, undoing the complement a negative word carries
    always_comb begin
        sgn   = word[WORD_W-1];
        exp_u = sgn ? ~word[WORD_W-2 -: EXP_W] : word[WORD_W-2 -: EXP_W];
        mant  = {sgn, word[FRAC_W-1:0]};
    end

    // Classify by where the binary point lands relative to the word
    always_comb begin
        if ({1'b0, exp_u} >= OVF_LIM)
            cls = CLS_OVF;
        else if ({1'b0, exp_u} < ZERO_LIM)
            cls = CLS_ZERO;
        else
            cls = CLS_NORMAL;
    end

endmodule

// File: rtl/fx_align.sv
// Module: fx_align
// Positions the signed fraction so the integer bits fill one field and
// the bits below the binary point fill another. A log-depth left shifter
// is used, one generated stage per bit of the shift amount.
// Assumes: the caller only trusts the outputs for in-range exponents
// (bias <= exp < bias + WORD_W); other exponents give don't-care values.
module fx_align #(
    parameter int WORD_W = 36,
    parameter int EXP_W  = 8
) (
    input  logic [EXP_W-1:0]            exp_u,
    input  logic [WORD_W-EXP_W-1:0]     mant,
    output logic [WORD_W-1:0]           int_part,
    output logic [WORD_W-EXP_W-2:0]     frac_part
);
    localparam int FRAC_W = WORD_W - 1 - EXP_W;
    localparam int BIAS   = 1 << (EXP_W - 1);
    localparam int SH_W   = $clog2(WORD_W);
    localparam int PW     = FRAC_W + 1 + WORD_W;

    logic [EXP_W-1:0] rel;
    logic [SH_W-1:0]  sh;
    logic [PW-1:0]    stg [SH_W+1];

    // Shift distance is the exponent above the bias
    always_comb begin
        rel = exp_u - EXP_W'(BIAS);
        sh  = rel[SH_W-1:0];
    end

    // Sign-extend the fraction into the wide working field
    assign stg[0] = {{(PW-FRAC_W-1){mant[FRAC_W]}}, mant};

    genvar k;
    generate
        for (k = 0; k < SH_W; k++) begin : g_stage
            // Each stage shifts by a power of two when its bit is set
            assign stg[k+1] = sh[k] ? (stg[k] << (1 << k)) : stg[k];
        end
    endgenerate

    // Split at the binary point: integer above, fraction below
    always_comb begin
        int_part  = stg[SH_W][FRAC_W +: WORD_W];
        frac_part = stg[SH_W][FRAC_W-1:0];
    end

endmodule

// File: rtl/fx_round.sv
// Module: fx_round
// Applies either rounding mode by adding a single constant to the bits
// below the binary point; the carry out increments the integer part.
// Assumes: int_part is floor of the value (arithmetic shift semantics).
module fx_round
    import fx_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int FRAC_W = 27
) (
    input  logic [WORD_W-1:0] int_part,
    input  logic [FRAC_W-1:0] frac_part,
    input  logic              neg,
    input  fx_rnd_e           mode,
    output logic [WORD_W-1:0] result
);
    localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);

    logic [FRAC_W-1:0] rc;
    logic [FRAC_W:0]   sum;

    // Pick the constant: one-half, or all ones for negatives, else zero
    always_comb begin
        if (mode == RND_HALF_UP)
            rc = HALF;
        else if (neg)
            rc = '1;
        else
            rc = '0;
    end

    // Add constant to the fraction and fold the carry into the integer
    always_comb begin
        sum    = {1'b0, frac_part} + {1'b0, rc};
        result = int_part + {{(WORD_W-1){1'b0}}, sum[FRAC_W]};
    end

endmodule

// File: rtl/fx_float_to_int.sv
// Module: fx_float_to_int (top)
// Converts one floating word per strobe into a registered integer with a
// result strobe and an overflow flag. On overflow the integer register is
// left untouched.
// Assumes: synchronous active-low reset; one result per input, latency 1.
module fx_float_to_int
    import fx_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int EXP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_round,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_int,
    output logic              out_ovf
);
    localparam int FRAC_W = WORD_W - 1 - EXP_W;

    logic [EXP_W-1:0]  exp_u;
    logic [FRAC_W:0]   mant;
    fx_cls_e           cls;
    logic [WORD_W-1:0] aln_int;
    logic [FRAC_W-1:0] aln_frac;
    logic [WORD_W-1:0] rnd_int;
    fx_rnd_e           mode;

    assign mode = fx_rnd_e'(in_round);

    fx_unpack #(.WORD_W(WORD_W), .EXP_W(EXP_W)) u_unpack (
        .word  (in_word),
        .exp_u (exp_u),
        .mant  (mant),
        .cls   (cls)
    );

    fx_align #(.WORD_W(WORD_W), .EXP_W(EXP_W)) u_align (
        .exp_u     (exp_u),
        .mant      (mant),
        .int_part  (aln_int),
        .frac_part (aln_frac)
    );

    fx_round #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_round (
        .int_part  (aln_int),
        .frac_part (aln_frac),
        .neg       (mant[FRAC_W]),
        .mode      (mode),
        .result    (rnd_int)
    );

    // Result register: strobe, flag, and integer held across overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ovf   <= 1'b0;
            out_int   <= '0;
        end else begin
            out_valid <= in_valid;
            out_ovf   <= in_valid && (cls == CLS_OVF);
            if (in_valid && (cls != CLS_OVF))
                out_int <= (cls == CLS_ZERO) ? '0 : rnd_int;
        end
    end

    // R2: a strobe in produces a strobe out one cycle later
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no strobe in, no strobe out
    p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4: the flag only accompanies a result strobe
    p_ovf_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> out_valid);

    // R3: on overflow the integer keeps its earlier contents
    p_no_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> (out_int == $past(out_int)));

    // R5: exponents below the bias give zero
    p_small_is_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls == CLS_ZERO) |=> (out_int == '0) && !out_ovf);

    // R6: positive words in toward-zero mode are never incremented
    p_pos_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_round && !mant[FRAC_W]) |-> (rnd_int == aln_int));

    // R8: below one-half, half-up mode leaves the integer part alone
    p_below_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_round && !aln_frac[FRAC_W-1]) |-> (rnd_int == aln_int));

endmodule

// File: tb/sim_fx_float_to_int.sv
module sim_fx_float_to_int;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [35:0] in_word = '0;
    logic        in_round = 1'b0;
    logic        out_valid;
    logic [35:0] out_int;
    logic        out_ovf;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic [35:0] exp_int_q [$];
    logic        exp_ovf_q [$];
    string       tag_q     [$];
    logic [35:0] held = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fx_float_to_int u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_round(in_round), .out_valid(out_valid), .out_int(out_int),
        .out_ovf(out_ovf)
    );

    // Build a word from sign, exponent and 27-bit fraction magnitude
    function automatic logic [35:0] fw(input bit neg, input int e, input int f);
        logic [35:0] p;
        p = {1'b0, e[7:0], f[26:0]};
        return neg ? (~p + 36'd1) : p;
    endfunction

    // Reference model from the requirements (R1, R3, R5 to R9)
    function automatic logic [35:0] model(input logic [35:0] w, input logic rnd,
                                          input logic [35:0] prev, output logic ovf);
        logic [7:0] ev;
        int     e, s;
        longint m, q, rem;
        ev  = w[35] ? ~w[34:27] : w[34:27];
        e   = int'(ev);
        m   = longint'($signed({w[35], w[26:0]}));
        ovf = 1'b0;
        if (e >= 164) begin
            ovf = 1'b1;
            return prev;
        end
        if (e < 128) return '0;
        if (e >= 155) begin
            q = m <<< (e - 155);
        end else begin
            s   = 155 - e;
            q   = m >>> s;
            rem = m - (q <<< s);
            if (rnd) begin
                if (rem * 2 >= (longint'(1) << s)) q = q + 1;
            end else if (m < 0 && rem != 0) begin
                q = q + 1;
            end
        end
        return q[35:0];
    endfunction

    // Driver: present one word and push the expected result
    task automatic send(input logic [35:0] w, input logic rnd, input string tag);
        logic [35:0] ev;
        logic        eo;
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        in_round = rnd;
        ev = model(w, rnd, held, eo);
        if (!eo) held = ev;
        exp_int_q.push_back(ev);
        exp_ovf_q.push_back(eo);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: pop and compare on each result strobe
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_ovf && !out_valid) begin
                tests++; fails++;
                $display("FAIL R4: flag without strobe, got ovf=%0b expected 0", out_ovf);
            end
            if (out_valid) begin
                tests++;
                if (exp_int_q.size() == 0) begin
                    fails++;
                    $display("FAIL R2: strobe with nothing pending, got valid=1 expected 0");
                end else begin
                    logic [35:0] ei;
                    logic        eo;
                    string       t;
                    ei = exp_int_q.pop_front();
                    eo = exp_ovf_q.pop_front();
                    t  = tag_q.pop_front();
                    if (out_int !== ei || out_ovf !== eo) begin
                        fails++;
                        $display("FAIL %s: got int=%0d ovf=%0b expected int=%0d ovf=%0b",
                                 t, $signed(out_int), out_ovf, $signed(ei), eo);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R2: watchdog expired, got running expected finished");
            finish_run();
        end
    end

    initial begin
        // R10: reset state
        in_valid = 1'b1;
        in_word  = fw(0, 130, 5 << 24);
        repeat (3) @(negedge clk);
        tests++;
        if (out_valid !== 1'b0 || out_ovf !== 1'b0 || out_int !== '0) begin
            fails++;
            $display("FAIL R10: got valid=%0b ovf=%0b int=%0d expected 0 0 0",
                     out_valid, out_ovf, out_int);
        end
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1 / R9: exact values and left shifts
        send(fw(0, 129, 1 << 26), 1'b0, "R1");
        send(fw(0, 155, 12345), 1'b1, "R9");
        send(fw(1, 160, 777), 1'b0, "R9");
        send(fw(0, 163, (1 << 27) - 1), 1'b0, "R9");
        send(fw(1, 163, (1 << 27) - 1), 1'b1, "R9");
        idle(2);

        // R5: too small for any integer bit
        send(fw(0, 127, 1 << 26), 1'b1, "R5");
        send(fw(1, 100, 3 << 25), 1'b0, "R5");
        send(fw(1, 127, (1 << 27) - 1), 1'b1, "R5");
        idle(1);

        // R6: positive, toward zero
        send(fw(0, 130, 5 << 24), 1'b0, "R6");
        send(fw(0, 128, 3 << 25), 1'b0, "R6");
        send(fw(0, 154, (1 << 27) - 1), 1'b0, "R6");

        // R7: negative, toward zero
        send(fw(1, 130, 5 << 24), 1'b0, "R7");
        send(fw(1, 128, 3 << 25), 1'b0, "R7");
        send(fw(1, 130, 3 << 25), 1'b0, "R7");
        idle(3);

        // R8: half up, including ties on both signs
        send(fw(0, 130, 5 << 24), 1'b1, "R8");
        send(fw(0, 130, 9 << 23), 1'b1, "R8");
        send(fw(1, 130, 5 << 24), 1'b1, "R8");
        send(fw(1, 130, 11 << 23), 1'b1, "R8");
        send(fw(0, 128, 1 << 26), 1'b1, "R8");
        send(fw(1, 128, 3 << 25), 1'b1, "R8");
        idle(2);

        // R3 / R4: overflow right after a normal result, then back to back
        send(fw(0, 140, 3 << 25), 1'b1, "R4");
        send(fw(0, 164, 1 << 26), 1'b0, "R3");
        send(fw(1, 200, 1 << 26), 1'b1, "R3");
        send(fw(0, 255, 7), 1'b0, "R3");
        send(fw(0, 129, 1 << 26), 1'b0, "R4");
        idle(4);

        tests++;
        if (exp_int_q.size() != 0) begin
            fails++;
            $display("FAIL R2: got %0d results missing expected 0", exp_int_q.size());
        end
        finish_run();
    end
endmodule